// File: doc/BRIEF.md
# Vendor Capability List Scanner

This engine runs on the requesting side of a PCI function's configuration space. Given a head pointer, it follows the capability linked list through a simple dword read port. It picks out the vendor-specific capabilities that describe a structure. For each of the four structure kinds it keeps the BAR index, the byte offset and the byte length of the first acceptable entry in list order. For the notification kind it also keeps the queue address multiplier.

Software or a boot sequencer pulses `start_i` with the head pointer and then waits for `done_o`. When the walk ends, `found_o` shows which structures were located. `legacy_o` is raised when the list ended cleanly but held no usable entry, so the function must be driven through its legacy layout. `loop_err_o` is raised when the list did not end within the visit limit.

Top module: `cap_scan`

## Requirements
- R1: While reset is held, and after it is released, `done_o`, `rd_req_o`, `found_o`, `legacy_o` and `loop_err_o` are all 0.
- R2: `rd_req_o` stays high, with `rd_addr_o` unchanged, until a cycle in which `rd_valid_i` is high. That cycle completes the read, and `rd_data_i` is taken in that cycle. Every read address is dword aligned.
- R3: The two low bits of the head pointer are ignored. A head pointer of zero (after masking) finishes the walk with no read and raises `legacy_o`.
- R4: An entry is considered only when byte 0 of its first dword (the ID, bits 7:0) equals 0x09.
- R5: The structure kind is byte 3 of the first dword (bits 31:24). Kind 1 = common, 2 = notify, 3 = ISR, 4 = device, and kind k sets `found_o[k-1]`. An entry of any other kind is skipped.
- R6: The BAR index is byte 4 of the entry (bits 7:0 of the second dword). Only values 0 to 5 are accepted. An entry with any other value is skipped and records nothing.
- R7: When several accepted entries name the same kind, the one that comes first in the list is kept. For a kind that was not found, the `bar_o`, `off_o` and `len_o` slices read 0.
- R8: Offset is the dword at byte 8 and length is the dword at byte 12. For the notify kind, `mult_o` takes the dword at byte 16. `mult_o` reads 0 when no notify entry was found.
- R9: `legacy_o` is high after a walk that ended without error and found no kind.
- R10: The next pointer is byte 1 of the first dword (bits 15:8), with its two low bits ignored. A next pointer of zero ends the walk.
- R11: At most 48 entries are visited. A list of exactly 48 entries ends normally. If the 48th entry's next pointer is non-zero, the walk ends with `loop_err_o` high and `legacy_o` low.
- R12: `start_i` is ignored while a walk is running. A start given while idle or done begins a new walk and clears all earlier results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk |
| head_ptr_i | input | 8 | Byte address of the first capability |
| rd_req_o | output | 1 | Dword read request, held until answered |
| rd_addr_o | output | 8 | Byte address of the requested dword |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 32 | Read response data, little-endian |
| done_o | output | 1 | Walk finished, held until the next start |
| legacy_o | output | 1 | Finished cleanly with nothing found |
| loop_err_o | output | 1 | Walk stopped at the visit limit |
| found_o | output | 4 | One bit per structure kind |
| bar_o | output | 4x3 | BAR index per kind |
| off_o | output | 4x32 | Offset per kind |
| len_o | output | 4x32 | Length per kind |
| mult_o | output | 32 | Notify address multiplier |

## Verification
If the walk state is corrupted, the first thing to go wrong at the ports is the read address. A wrong step reads at the wrong offset within an entry, or follows the wrong next pointer, in the very next request. This shows up as a wrong `found_o` pattern or wrong field values once `done_o` rises, within one walk. A broken first-match guard shows only on lists that repeat a kind, so those lists put the accepted entry ahead of rejected and later duplicates. A miscounted visit counter shows only at the limit, which is why one chain has exactly 48 entries and another chain loops.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int DW        = 32;
  localparam logic [7:0] VND_ID  = 8'h09;
  localparam logic [7:0] BAR_MAX = 8'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_BAR, ST_OFF, ST_LEN, ST_MULT, ST_NEXT, ST_DONE
  } walk_state_e;
endpackage

// File: rtl/cap_store.sv
module cap_store
  import cap_pkg::*;
#(
  parameter int N_TYPES    = 4,
  parameter int NOTIFY_IDX = 1,
  localparam int IW        = $clog2(N_TYPES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        commit_i,
  input  logic [IW-1:0]               cm_idx_i,
  input  logic [2:0]                  cm_bar_i,
  input  logic [DW-1:0]               cm_off_i,
  input  logic [DW-1:0]               cm_len_i,
  input  logic [DW-1:0]               cm_mult_i,
  output logic [N_TYPES-1:0]          found_o,
  output logic [N_TYPES-1:0][2:0]     bar_o,
  output logic [N_TYPES-1:0][DW-1:0]  off_o,
  output logic [N_TYPES-1:0][DW-1:0]  len_o,
  output logic [DW-1:0]               mult_o
);
  logic          found_q [N_TYPES];
  logic [2:0]    bar_q   [N_TYPES];
  logic [DW-1:0] off_q   [N_TYPES];
  logic [DW-1:0] len_q   [N_TYPES];
  logic [DW-1:0] mult_q;

  for (genvar i = 0; i < N_TYPES; i++) begin : g_slot
    wire hit = commit_i && (cm_idx_i == IW'(i)) && !found_q[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        found_q[i] <= 1'b0;
        bar_q[i]   <= '0;
        off_q[i]   <= '0;
        len_q[i]   <= '0;
      end else if (clear_i) begin
        found_q[i] <= 1'b0;
        bar_q[i]   <= '0;
        off_q[i]   <= '0;
        len_q[i]   <= '0;
      end else if (hit) begin
        found_q[i] <= 1'b1;
        bar_q[i]   <= cm_bar_i;
        off_q[i]   <= cm_off_i;
        len_q[i]   <= cm_len_i;
      end
    end

    assign found_o[i] = found_q[i];
    assign bar_o[i]   = bar_q[i];
    assign off_o[i]   = off_q[i];
    assign len_o[i]   = len_q[i];

    // R7: an accepted entry is never replaced by a later one
    a_r7_keep_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      found_q[i] && !clear_i |=> found_q[i] && $stable(bar_q[i])
                                 && $stable(off_q[i]) && $stable(len_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                                   mult_q <= '0;
    else if (clear_i)                                              mult_q <= '0;
    else if (commit_i && cm_idx_i == IW'(NOTIFY_IDX) && !found_q[NOTIFY_IDX]) mult_q <= cm_mult_i;
  end

  assign mult_o = mult_q;
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import cap_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int N_TYPES     = 4,
  parameter int NOTIFY_IDX  = 1,
  parameter int VISIT_LIMIT = 48,
  localparam int IW         = $clog2(N_TYPES),
  localparam int VCW        = $clog2(VISIT_LIMIT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PTR_W-1:0]   head_ptr_i,
  output logic               rd_req_o,
  output logic [PTR_W-1:0]   rd_addr_o,
  input  logic               rd_valid_i,
  input  logic [DW-1:0]      rd_data_i,
  input  logic [N_TYPES-1:0] found_i,
  output logic               clear_o,
  output logic               commit_o,
  output logic [IW-1:0]      cm_idx_o,
  output logic [2:0]         cm_bar_o,
  output logic [DW-1:0]      cm_off_o,
  output logic [DW-1:0]      cm_len_o,
  output logic [DW-1:0]      cm_mult_o,
  output logic               done_o,
  output logic               err_o
);
  localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(3);

  walk_state_e      state_q;
  logic [PTR_W-1:0] ptr_q, next_q;
  logic [IW-1:0]    idx_q;
  logic [2:0]       bar_q;
  logic [DW-1:0]    off_q, len_q;
  logic [VCW-1:0]   visits_q;
  logic             err_q;

  wire        idle     = (state_q == ST_IDLE) || (state_q == ST_DONE);
  wire        acc      = rd_req_o && rd_valid_i;
  wire [7:0]  kind     = rd_data_i[31:24];
  wire        kind_ok  = (kind >= 8'd1) && (kind <= 8'(N_TYPES));
  wire [IW-1:0] kind_idx = IW'(kind - 8'd1);
  wire        is_notify = (idx_q == IW'(NOTIFY_IDX));

  always_comb begin
    rd_req_o  = 1'b0;
    rd_addr_o = ptr_q;
    unique case (state_q)
      ST_HDR:  begin rd_req_o = 1'b1; rd_addr_o = ptr_q; end
      ST_BAR:  begin rd_req_o = 1'b1; rd_addr_o = ptr_q + PTR_W'(4); end
      ST_OFF:  begin rd_req_o = 1'b1; rd_addr_o = ptr_q + PTR_W'(8); end
      ST_LEN:  begin rd_req_o = 1'b1; rd_addr_o = ptr_q + PTR_W'(12); end
      ST_MULT: begin rd_req_o = 1'b1; rd_addr_o = ptr_q + PTR_W'(16); end
      default: ;
    endcase
  end

  assign clear_o   = idle && start_i;
  assign commit_o  = acc && ((state_q == ST_LEN && !is_notify) || state_q == ST_MULT);
  assign cm_idx_o  = idx_q;
  assign cm_bar_o  = bar_q;
  assign cm_off_o  = off_q;
  assign cm_len_o  = (state_q == ST_LEN) ? rd_data_i : len_q;
  assign cm_mult_o = rd_data_i;
  assign done_o    = (state_q == ST_DONE);
  assign err_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      next_q   <= '0;
      idx_q    <= '0;
      bar_q    <= '0;
      off_q    <= '0;
      len_q    <= '0;
      visits_q <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          next_q   <= head_ptr_i & ALIGN;
          visits_q <= '0;
          err_q    <= 1'b0;
          state_q  <= ST_NEXT;
        end
        ST_HDR: if (acc) begin
          next_q <= rd_data_i[15:8] & ALIGN;
          idx_q  <= kind_idx;
          state_q <= (rd_data_i[7:0] == VND_ID && kind_ok && !found_i[kind_idx])
                     ? ST_BAR : ST_NEXT;
        end
        ST_BAR: if (acc) begin
          bar_q   <= rd_data_i[2:0];
          state_q <= (rd_data_i[7:0] <= BAR_MAX) ? ST_OFF : ST_NEXT;
        end
        ST_OFF: if (acc) begin
          off_q   <= rd_data_i;
          state_q <= ST_LEN;
        end
        ST_LEN: if (acc) begin
          len_q   <= rd_data_i;
          state_q <= is_notify ? ST_MULT : ST_NEXT;
        end
        ST_MULT: if (acc) state_q <= ST_NEXT;
        ST_NEXT: begin
          if (next_q == '0) begin
            state_q <= ST_DONE;
          end else if (visits_q == VCW'(VISIT_LIMIT)) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            ptr_q    <= next_q;
            visits_q <= visits_q + 1'b1;
            state_q  <= ST_HDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

  a_r2_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[1:0] == 2'b00);

  a_r11_visit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    visits_q <= VCW'(VISIT_LIMIT));

  a_r10_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);

  a_r12_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i && start_i |=> rd_req_o);
endmodule

// File: rtl/cap_scan.sv
module cap_scan
  import cap_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int N_TYPES     = 4,
  parameter int NOTIFY_IDX  = 1,
  parameter int VISIT_LIMIT = 48,
  localparam int IW         = $clog2(N_TYPES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [PTR_W-1:0]            head_ptr_i,
  output logic                        rd_req_o,
  output logic [PTR_W-1:0]            rd_addr_o,
  input  logic                        rd_valid_i,
  input  logic [DW-1:0]               rd_data_i,
  output logic                        done_o,
  output logic                        legacy_o,
  output logic                        loop_err_o,
  output logic [N_TYPES-1:0]          found_o,
  output logic [N_TYPES-1:0][2:0]     bar_o,
  output logic [N_TYPES-1:0][DW-1:0]  off_o,
  output logic [N_TYPES-1:0][DW-1:0]  len_o,
  output logic [DW-1:0]               mult_o
);
  logic          clear, commit, err;
  logic [IW-1:0] cm_idx;
  logic [2:0]    cm_bar;
  logic [DW-1:0] cm_off, cm_len, cm_mult;

  cap_fsm #(
    .PTR_W(PTR_W), .N_TYPES(N_TYPES), .NOTIFY_IDX(NOTIFY_IDX), .VISIT_LIMIT(VISIT_LIMIT)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .head_ptr_i,
    .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_data_i,
    .found_i(found_o), .clear_o(clear), .commit_o(commit),
    .cm_idx_o(cm_idx), .cm_bar_o(cm_bar), .cm_off_o(cm_off),
    .cm_len_o(cm_len), .cm_mult_o(cm_mult),
    .done_o, .err_o(err)
  );

  cap_store #(.N_TYPES(N_TYPES), .NOTIFY_IDX(NOTIFY_IDX)) u_store (
    .clk_i, .rst_ni, .clear_i(clear), .commit_i(commit),
    .cm_idx_i(cm_idx), .cm_bar_i(cm_bar), .cm_off_i(cm_off),
    .cm_len_i(cm_len), .cm_mult_i(cm_mult),
    .found_o, .bar_o, .off_o, .len_o, .mult_o
  );

  assign loop_err_o = done_o && err;
  assign legacy_o   = done_o && !err && (found_o == '0);

  a_r9_legacy_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_o |-> !loop_err_o && done_o);
endmodule

// File: tb/cap_scan_bench.sv
module cap_scan_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        head = '0;
  logic              rd_req;
  logic [7:0]        rd_addr;
  logic              rd_valid = 1'b0;
  logic [31:0]       rd_data = '0;
  logic              done, legacy, loop_err;
  logic [3:0]        found;
  logic [3:0][2:0]   bar;
  logic [3:0][31:0]  off, len;
  logic [31:0]       mult;

  int n_run = 0, n_fail = 0, cycles = 0, lat = 0, wait_cnt = 0;
  logic [31:0] mem [64];

  always #5 clk = ~clk;

  cap_scan u_cap_scan (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .head_ptr_i(head),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .done_o(done), .legacy_o(legacy), .loop_err_o(loop_err),
    .found_o(found), .bar_o(bar), .off_o(off), .len_o(len), .mult_o(mult)
  );

  // read responder with programmable latency
  initial forever begin
    @(negedge clk);
    if (rd_valid) rd_valid = 1'b0;
    else if (rd_req) begin
      if (wait_cnt >= lat) begin
        rd_valid = 1'b1;
        rd_data  = mem[rd_addr[7:2]];
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
  endtask

  task automatic put_cap(input logic [7:0] p, input logic [7:0] id, input logic [7:0] nxt,
                         input logic [7:0] kind, input logic [7:0] b,
                         input logic [31:0] o, input logic [31:0] l, input logic [31:0] m);
    mem[p[7:2]]          = {kind, 8'd20, nxt, id};
    mem[6'(p[7:2] + 1)]  = {24'h0, b};
    mem[6'(p[7:2] + 2)]  = o;
    mem[6'(p[7:2] + 3)]  = l;
    mem[6'(p[7:2] + 4)]  = m;
  endtask

  task automatic pulse_start(input logic [7:0] h);
    @(negedge clk);
    head = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk("done reached", {63'b0, done}, 64'd1);
  endtask

  task automatic walk(input logic [7:0] h);
    pulse_start(h);
    wait_done();
  endtask

  typedef struct packed {
    logic [7:0] id;
    logic [7:0] kind;
    logic [7:0] b;
    logic [3:0] exp_found;
    logic       exp_legacy;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h09, 8'd1, 8'd0,   4'b0001, 1'b0},  // R5 common
    '{8'h09, 8'd2, 8'd5,   4'b0010, 1'b0},  // R5 R6 R8 notify, BAR 5
    '{8'h09, 8'd3, 8'd2,   4'b0100, 1'b0},  // R5 ISR
    '{8'h09, 8'd4, 8'd3,   4'b1000, 1'b0},  // R5 device
    '{8'h0A, 8'd1, 8'd0,   4'b0000, 1'b1},  // R4 wrong ID
    '{8'h09, 8'd5, 8'd0,   4'b0000, 1'b1},  // R5 kind 5
    '{8'h09, 8'd0, 8'd1,   4'b0000, 1'b1},  // R5 kind 0
    '{8'h09, 8'd1, 8'd6,   4'b0000, 1'b1},  // R6 BAR 6
    '{8'h09, 8'd3, 8'hFF,  4'b0000, 1'b1}   // R6 BAR 0xFF
  };

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {63'b0, done}, 0);
    chk("R1 req in reset", {63'b0, rd_req}, 0);
    chk("R1 found in reset", {60'b0, found}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", {59'b0, done, rd_req, legacy, loop_err, 1'b0}, 0);

    // table of single-entry lists
    foreach (VECS[i]) begin
      clear_mem();
      lat = i % 3;
      put_cap(8'h40, VECS[i].id, 8'h00, VECS[i].kind, VECS[i].b,
              32'h1000 + i, 32'h20 + i, 32'hA0 + i);
      walk(8'h40);
      chk("R4 R5 R6 found", {60'b0, found}, {60'b0, VECS[i].exp_found});
      chk("R9 legacy", {63'b0, legacy}, {63'b0, VECS[i].exp_legacy});
      if (VECS[i].exp_found != 0) begin
        chk("R8 offset", {32'b0, off[VECS[i].kind - 1]}, 64'h1000 + i);
        chk("R8 length", {32'b0, len[VECS[i].kind - 1]}, 64'h20 + i);
        chk("R6 bar", {61'b0, bar[VECS[i].kind - 1]}, {56'b0, VECS[i].b});
      end else begin
        chk("R7 unfound zero", {off[0] | off[1] | off[2] | off[3]}, 0);
      end
      chk("R8 mult", {32'b0, mult}, (VECS[i].kind == 2 && VECS[i].exp_found != 0) ? 64'hA0 + i : 0);
    end

    // R3 zero head
    clear_mem();
    lat = 0;
    walk(8'h03);
    chk("R3 zero head legacy", {62'b0, legacy, loop_err}, 64'b10);
    chk("R3 zero head no read", {63'b0, rd_req}, 0);

    // R3 R10 pointer masking, two-entry chain
    clear_mem();
    put_cap(8'h40, 8'h09, 8'h51, 8'd3, 8'd1, 32'h300, 32'h4, 32'h0);
    put_cap(8'h50, 8'h09, 8'h00, 8'd4, 8'd4, 32'h400, 32'h80, 32'h0);
    walk(8'h43);
    chk("R3 R10 masked pointers", {60'b0, found}, 64'b1100);
    chk("R10 second entry offset", {32'b0, off[3]}, 64'h400);

    // R6 R7 R8 first match with rejects and duplicates
    clear_mem();
    lat = 1;
    put_cap(8'h20, 8'h09, 8'h38, 8'd3, 8'd7, 32'hBAD0, 32'h1, 32'h0);
    put_cap(8'h38, 8'h09, 8'h50, 8'd1, 8'd1, 32'hA000, 32'h38, 32'h0);
    put_cap(8'h50, 8'h09, 8'h68, 8'd1, 8'd2, 32'hB000, 32'h38, 32'h0);
    put_cap(8'h68, 8'h09, 8'h80, 8'd2, 8'd4, 32'h2000, 32'h10, 32'h4);
    put_cap(8'h80, 8'h09, 8'h98, 8'd2, 8'd0, 32'h3000, 32'h10, 32'h8);
    put_cap(8'h98, 8'h09, 8'h00, 8'd3, 8'd2, 32'h5000, 32'h1, 32'h0);
    walk(8'h20);
    chk("R7 found set", {60'b0, found}, 64'b0111);
    chk("R7 first common offset", {32'b0, off[0]}, 64'hA000);
    chk("R7 first common bar", {61'b0, bar[0]}, 64'd1);
    chk("R8 first notify mult", {32'b0, mult}, 64'h4);
    chk("R8 notify length", {32'b0, len[1]}, 64'h10);
    chk("R6 ISR after bad BAR", {32'b0, off[2]}, 64'h5000);

    // R12 start ignored while busy
    lat = 2;
    pulse_start(8'h20);
    repeat (4) @(negedge clk);
    head = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R12 busy start ignored", {32'b0, off[0]}, 64'hA000);
    chk("R12 busy start found", {60'b0, found}, 64'b0111);

    // R12 R9 restart clears earlier results
    put_cap(8'hC0, 8'h11, 8'h00, 8'd1, 8'd0, 32'h1, 32'h1, 32'h0);
    walk(8'hC0);
    chk("R12 cleared found", {60'b0, found}, 0);
    chk("R12 cleared mult", {32'b0, mult}, 0);
    chk("R9 legacy after non-vendor", {63'b0, legacy}, 1);

    // R11 exactly 48 entries
    clear_mem();
    lat = 0;
    for (int k = 1; k <= 48; k++)
      mem[k] = {8'd1, 8'd4, (k == 48) ? 8'h00 : 8'(4 * (k + 1)), 8'h01};
    walk(8'h04);
    chk("R11 48 entries no error", {62'b0, loop_err, legacy}, 64'b01);

    // R11 looped list
    mem[48] = {8'd1, 8'd4, 8'h04, 8'h01};
    walk(8'h04);
    chk("R11 loop error", {62'b0, loop_err, legacy}, 64'b10);
    chk("R11 done on loop", {63'b0, done}, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule